// File: doc/BRIEF.md
# Secure Address Router

This block sits at the entry of an interconnect port. Each request address is compared with a table of target windows that is fixed by parameters, and the block decides which downstream target gets the request. It also works out whether the request counts as secure or non-secure and enforces that policy. When the request has nowhere legal to go, the block answers it with a decode error. The table holds one base/mask pair per target and a flag marking each target as secure-only. A separate window selects the port's own register block.

The port's security mode is a static input with three behaviours:
- every request is treated as secure;
- every request is treated as non-secure;
- the protection bit of each request decides.

A request with no legal destination returns the AXI-style decode-error code. The same outcome also appears on a one-bit error line for an initiator of the AHB-Lite kind. There are two ways to fail: an address outside every window, and a non-secure request that lands on a secure-only target. Both fail in the same way.

A small state machine registers the result. Its states are ST_IDLE (no response), ST_ROUTE (legal destination) and ST_FAULT (decode error). From any state, the machine moves on each clock as follows:
- with `req_valid` low, it takes the *quiet* transition to ST_IDLE;
- with `req_valid` high and a legal destination, it takes the *grant* transition to ST_ROUTE;
- with `req_valid` high and no legal destination, it takes the *reject* transition to ST_FAULT.

Top module: `addr_sec_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid`, `tgt_sel`, `reg_sel`, `req_nonsec`, `dec_err` and `ahb_err` are 0, and `rsp_code` is 2'b00.
- R2: The response belongs to the request presented at a clock edge and appears in the cycle after that edge. `rsp_valid` is 1 exactly in the cycles that follow a cycle with `req_valid` high. In every other cycle all outputs hold their idle values.
- R3: Target i matches when (`req_addr` & MASK[i]) == BASE[i]. When several targets match, only the lowest-numbered one is selected, and `tgt_sel` is one-hot on that target.
- R4: With `sec_mode` = 2'b00 (force secure), `req_nonsec` is 0 and secure-only targets are reachable.
- R5: With `sec_mode` = 2'b01 or 2'b11 (force non-secure), `req_nonsec` is 1 whatever the protection bit.
- R6: With `sec_mode` = 2'b10 (per request), `req_nonsec` equals `req_prot_ns` (0 = secure, 1 = non-secure).
- R7: A non-secure request whose winning target is secure-only gets a decode error with `tgt_sel` = 0. It does not fall through to a lower-priority matching target.
- R8: An address that matches no target and falls outside the register window gets a decode error with `tgt_sel` = 0 and `reg_sel` = 0.
- R9: An address that matches no target but falls inside the register window sets `reg_sel` with an OKAY response, for requests of either security.
- R10: `rsp_code` is 2'b11 (DECERR) when `dec_err` is 1 and 2'b00 (OKAY) otherwise. `ahb_err` is 1 exactly when `dec_err` is 1.
- R11: At most one of `tgt_sel` and `reg_sel` is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_prot_ns | input | 1 | Per-request protection bit (1 = non-secure) |
| sec_mode | input | 2 | Port security mode: 00 secure, 01/11 non-secure, 10 per request |
| rsp_valid | output | 1 | Routing result valid |
| tgt_sel | output | N_TGT | One-hot target select |
| reg_sel | output | 1 | Register window selected |
| req_nonsec | output | 1 | Effective security of the request (1 = non-secure) |
| dec_err | output | 1 | Decode error |
| rsp_code | output | 2 | Response code (00 OKAY, 11 DECERR) |
| ahb_err | output | 1 | One-bit error for an AHB-Lite-style initiator |

## Verification
The assertions assume that `req_addr`, `req_prot_ns` and `sec_mode` are stable and known during any cycle in which `req_valid` is high. They also assume that the register window overlaps no target window. The bench changes inputs only on the falling edge. It sweeps all four mode codes with both protection values over addresses in every window, on window edges and in the holes. It then mixes idle cycles with random requests whose top address nibble covers the whole map.

// File: rtl/asr_pkg.sv
package asr_pkg;

    typedef enum logic [1:0] {
        SM_SECURE = 2'b00,
        SM_NONSEC = 2'b01,
        SM_PERREQ = 2'b10,
        SM_RSVD   = 2'b11
    } sec_mode_e;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } rsp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ROUTE = 2'b01,
        ST_FAULT = 2'b10
    } rt_state_e;

endpackage

// File: rtl/asr_sec_resolve.sv
module asr_sec_resolve
    import asr_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       prot_ns,
    output logic       nonsec
);

    always_comb begin
        unique case (sec_mode_e'(mode))
            SM_SECURE: nonsec = 1'b0;
            SM_NONSEC: nonsec = 1'b1;
            SM_PERREQ: nonsec = prot_ns;
            SM_RSVD:   nonsec = 1'b1;
            default:   nonsec = 1'b1;
        endcase
    end

endmodule

// File: rtl/asr_region_match.sv
module asr_region_match #(
    parameter int                          N_TGT    = 4,
    parameter int                          ADDR_W   = 32,
    parameter logic [N_TGT-1:0][ADDR_W-1:0] BASE    = '0,
    parameter logic [N_TGT-1:0][ADDR_W-1:0] MASK    = '0,
    parameter logic [N_TGT-1:0]            SEC_ONLY = '0,
    parameter logic [ADDR_W-1:0]           REG_BASE = '0,
    parameter logic [ADDR_W-1:0]           REG_MASK = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_TGT-1:0]  win_oh,
    output logic              any_hit,
    output logic              win_sec,
    output logic              reg_hit
);

    logic [N_TGT-1:0] raw_hit;

    for (genvar g = 0; g < N_TGT; g++) begin : g_cmp
        assign raw_hit[g] = ((addr & MASK[g]) == BASE[g]);
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        win_oh = '0;
        for (int i = 0; i < N_TGT; i++) begin
            if (raw_hit[i] && !found) begin
                win_oh[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    assign any_hit = |raw_hit;
    assign win_sec = |(win_oh & SEC_ONLY);
    assign reg_hit = ((addr & REG_MASK) == REG_BASE);

    always_comb begin
        if (any_hit) begin
            AST_WIN_ONEHOT: assert ($onehot(win_oh)); // R3
        end
    end

endmodule

// File: rtl/asr_rsp_map.sv
module asr_rsp_map
    import asr_pkg::*;
(
    input  logic       active,
    input  logic       fault,
    output logic [1:0] rsp_code,
    output logic       ahb_err
);

    always_comb begin
        rsp_code = RSP_OKAY;
        if (active && fault) rsp_code = RSP_DECERR;
    end

    assign ahb_err = rsp_code[1];

endmodule

// File: rtl/addr_sec_router.sv
module addr_sec_router
    import asr_pkg::*;
#(
    parameter int                           N_TGT    = 4,
    parameter int                           ADDR_W   = 32,
    parameter logic [N_TGT-1:0][ADDR_W-1:0] TGT_BASE = {32'h3000_0000, 32'h3000_0000,
                                                        32'h1000_0000, 32'h0000_0000},
    parameter logic [N_TGT-1:0][ADDR_W-1:0] TGT_MASK = {32'hF000_0000, 32'hFFF0_0000,
                                                        32'hF000_0000, 32'hF000_0000},
    parameter logic [N_TGT-1:0]             TGT_SEC  = 4'b0110,
    parameter logic [ADDR_W-1:0]            REG_BASE = 32'hF000_0000,
    parameter logic [ADDR_W-1:0]            REG_MASK = 32'hFFFF_F000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_prot_ns,
    input  logic [1:0]        sec_mode,
    output logic              rsp_valid,
    output logic [N_TGT-1:0]  tgt_sel,
    output logic              reg_sel,
    output logic              req_nonsec,
    output logic              dec_err,
    output logic [1:0]        rsp_code,
    output logic              ahb_err
);

    localparam logic [N_TGT-1:0] NO_SEL = '0;

    rt_state_e        state_q, state_d;
    logic [N_TGT-1:0] win_oh, sel_q;
    logic             any_hit, win_sec, reg_hit, nonsec;
    logic             reg_q, ns_q, legal, fault;

    asr_sec_resolve u_sec (
        .mode    (sec_mode),
        .prot_ns (req_prot_ns),
        .nonsec  (nonsec)
    );

    asr_region_match #(
        .N_TGT    (N_TGT),
        .ADDR_W   (ADDR_W),
        .BASE     (TGT_BASE),
        .MASK     (TGT_MASK),
        .SEC_ONLY (TGT_SEC),
        .REG_BASE (REG_BASE),
        .REG_MASK (REG_MASK)
    ) u_match (
        .addr    (req_addr),
        .win_oh  (win_oh),
        .any_hit (any_hit),
        .win_sec (win_sec),
        .reg_hit (reg_hit)
    );

    // a window hit decides first; security then filters the winner only
    assign legal = any_hit ? !(nonsec && win_sec) : reg_hit;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ROUTE, ST_FAULT: begin
                if (!req_valid)  state_d = ST_IDLE;   // quiet
                else if (legal)  state_d = ST_ROUTE;  // grant
                else             state_d = ST_FAULT;  // reject
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= NO_SEL;
            reg_q   <= 1'b0;
            ns_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                sel_q <= (legal && any_hit) ? win_oh : NO_SEL;
                reg_q <= legal && !any_hit;
                ns_q  <= nonsec;
            end
        end
    end

    always_comb begin
        rsp_valid  = 1'b0;
        tgt_sel    = NO_SEL;
        reg_sel    = 1'b0;
        req_nonsec = 1'b0;
        fault      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ROUTE: begin
                rsp_valid  = 1'b1;
                tgt_sel    = sel_q;
                reg_sel    = reg_q;
                req_nonsec = ns_q;
            end
            ST_FAULT: begin
                rsp_valid  = 1'b1;
                req_nonsec = ns_q;
                fault      = 1'b1;
            end
            default: ;
        endcase
    end

    assign dec_err = fault;

    asr_rsp_map u_rsp (
        .active   (rsp_valid),
        .fault    (fault),
        .rsp_code (rsp_code),
        .ahb_err  (ahb_err)
    );

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && tgt_sel == NO_SEL && !dec_err)); // R2
    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tgt_sel, reg_sel})); // R11
    AST_ERR_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (tgt_sel == NO_SEL && !reg_sel)); // R8
    AST_NS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        req_nonsec |-> ((tgt_sel & TGT_SEC) == NO_SEL)); // R7
    AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (rsp_code == RSP_DECERR && ahb_err)); // R10
    AST_OK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_err |-> (rsp_code == RSP_OKAY && !ahb_err)); // R10
    AST_FORCE_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_mode == 2'b00) |=> !req_nonsec); // R4
    AST_FORCE_NS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_mode[0]) |=> req_nonsec); // R5
    AST_PER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_mode == 2'b10) |=> (req_nonsec == $past(req_prot_ns))); // R6

endmodule

// File: tb/sim_addr_sec_router.sv
`timescale 1ns/1ps
module sim_addr_sec_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_prot_ns = 1'b0;
    logic [1:0]  sec_mode = 2'b00;
    logic        rsp_valid, reg_sel, req_nonsec, dec_err, ahb_err;
    logic [3:0]  tgt_sel;
    logic [1:0]  rsp_code;

    addr_sec_router u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_prot_ns(req_prot_ns), .sec_mode(sec_mode), .rsp_valid(rsp_valid),
        .tgt_sel(tgt_sel), .reg_sel(reg_sel), .req_nonsec(req_nonsec),
        .dec_err(dec_err), .rsp_code(rsp_code), .ahb_err(ahb_err)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench-side address map
    logic [31:0] m_base [4] = '{32'h0000_0000, 32'h1000_0000, 32'h3000_0000, 32'h3000_0000};
    logic [31:0] m_mask [4] = '{32'hF000_0000, 32'hF000_0000, 32'hFFF0_0000, 32'hF000_0000};
    bit          m_sec  [4] = '{1'b0, 1'b1, 1'b1, 1'b0};

    logic        e_valid, e_reg, e_ns, e_err, e_ahb;
    logic [3:0]  e_tgt;
    logic [1:0]  e_code;
    string       ns_tag, err_tag;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(bit v, logic [31:0] a, bit pns, logic [1:0] m);
        int hit;
        e_valid = v; e_tgt = 4'h0; e_reg = 0; e_ns = 0; e_err = 0;
        ns_tag = "R2"; err_tag = "R2";
        if (v) begin
            if (m == 2'b00)      begin e_ns = 0;   ns_tag = "R4"; end
            else if (m == 2'b10) begin e_ns = pns; ns_tag = "R6"; end
            else                 begin e_ns = 1;   ns_tag = "R5"; end
            hit = -1;
            for (int i = 3; i >= 0; i--)
                if ((a & m_mask[i]) == m_base[i]) hit = i;
            err_tag = "R3";
            if (hit >= 0) begin
                if (e_ns && m_sec[hit]) begin e_err = 1; err_tag = "R7"; end
                else e_tgt = 4'(1 << hit);
            end else if ((a & 32'hFFFF_F000) == 32'hF000_0000) begin
                e_reg = 1; err_tag = "R9";
            end else begin
                e_err = 1; err_tag = "R8";
            end
        end
        e_code = e_err ? 2'b11 : 2'b00;
        e_ahb  = e_err;
    endtask

    task automatic compare();
        chk("R2", "rsp_valid", rsp_valid, e_valid);
        chk("R3", "tgt_sel", tgt_sel, e_tgt);
        chk("R9", "reg_sel", reg_sel, e_reg);
        chk(ns_tag, "req_nonsec", req_nonsec, e_ns);
        chk(err_tag, "dec_err", dec_err, e_err);
        chk("R10", "rsp_code", rsp_code, e_code);
        chk("R10", "ahb_err", ahb_err, e_ahb);
        chk("R11", "sel_count", $countones({tgt_sel, reg_sel}) <= 1, 1);
    endtask

    task automatic step(bit v, logic [31:0] a, bit pns, logic [1:0] m);
        @(negedge clk);
        compare();
        req_valid = v; req_addr = a; req_prot_ns = pns; sec_mode = m;
        model(v, a, pns, m);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    logic [31:0] dir_addr [9] = '{32'h0000_0100, 32'h1000_0000, 32'h3000_0040,
                                  32'h300F_FFFC, 32'h3010_0000, 32'h5000_0000,
                                  32'hF000_0010, 32'hF000_1000, 32'hE000_0000};

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle in reset
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "tgt_sel", tgt_sel, 0);
        chk("R1", "reg_sel", reg_sel, 0);
        chk("R1", "req_nonsec", req_nonsec, 0);
        chk("R1", "dec_err", dec_err, 0);
        chk("R1", "rsp_code", rsp_code, 0);
        chk("R1", "ahb_err", ahb_err, 0);
        rst_n = 1'b1;
        model(0, '0, 0, 2'b00);
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 9; k++) begin
                    step(1, dir_addr[k], p[0], m[1:0]);
                    if (k == 4) step(0, 32'h1000_0000, 1, m[1:0]);
                end
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra;
            ra = $urandom;
            if (n % 5 == 0) ra = {4'hF, 16'h0000, ra[11:0]};
            step(($urandom % 4) != 0, ra, $urandom % 2 == 1, 2'($urandom % 4));
        end
        step(0, '0, 0, 2'b00);
        step(0, '0, 0, 2'b00);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            bad++;
            $display("FAIL R2 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

endmodule